// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is a serial peripheral master that moves one byte per command. A host sees two 32-bit words: a control/status word and a data word. To send a byte, the host writes it to the data word. It then writes the control word with the start bit set. The engine shifts the byte out most significant bit first, sampling the serial input at the same time, and reports busy until all eight bits have gone. The received byte then replaces the contents of the data word.

The serial clock is derived from the block clock by a programmable divider. Three select lines are driven directly from control bits. A loopback switch routes the outgoing bits back into the receiver in place of the serial input.

Every control write replaces the select levels, the loopback switch and the divider together. A write that arrives while a byte is moving is held back and applied when the byte completes.

Top module: `spi_master_top`

## Requirements
- R1: After reset the three select outputs are high, so the control word reads 0x00000015. The divider and loopback are 0, the data word reads 0, busy is 0, and both SCK and MOSI are low.
- R2: The control word is at byte address 0x0 and the data word at 0x4. Writes to any other address are ignored, and reads from any other address return 0. Control readback layout: select levels in bits 0, 2 and 4, busy in bit 1, loopback in bit 3, divider N in bits 31:27; all other bits read 0.
- R3: A control write with bit 1 set while idle starts a transfer. Busy reads 1 from the next cycle on, for exactly 16×(N+1) cycles.
- R4: SCK is low when idle. During a transfer each SCK half period lasts N+1 clock cycles, and the first half period is low.
- R5: MOSI carries the transmit byte most significant bit first. Each bit is held for a full SCK period, starting at the transfer start or at a falling SCK edge. MOSI is low when idle.
- R6: MISO is sampled at each rising SCK edge. The eight samples, first sample as the most significant bit, are readable from the data word when busy clears.
- R7: With control bit 3 set, the received byte equals the transmitted byte and MISO has no effect.
- R8: Select output i follows control bit 2×i as a line level. Each idle control write replaces the select, loopback and divider fields together.
- R9: A start written while busy does not begin or restart a transfer. Select, loopback and divider values written while busy leave the outputs unchanged until the byte completes, and then take effect, with the last such write winning.
- R10: An idle data write stores bits 7:0, and the data word reads them back zero-extended. A data write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte address of the accessed word |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | NUM_CS | Select line levels |

## Verification
The bench instantiates the block with its default parameters: an 8-bit transfer, a 5-bit divider field and a 4-bit address. Because the divider field is kept at full width, one run can program N = 0, 2, 5 and 31. That covers the shortest half period, the longest half period, and the wrap of the divider counter at its largest value. A behavioural model predicts SCK, MOSI, the select lines and the readback on every cycle, while MISO is driven from a pseudo-random sequence. This exposes off-by-one errors in edge timing and in bit order.

// File: rtl/spi_pkg.sv
package spi_pkg;
  // strobes from the control sequencer to the shift datapath
  typedef struct packed {
    logic active;  // a byte is in flight
    logic load;    // copy data word into shifter
    logic sample;  // rising SCK: capture input bit
    logic shift;   // falling SCK: advance shifter
    logic finish;  // last edge: deposit received byte
  } engStrobe_t;
endpackage

// File: rtl/spi_ctrl.sv
module spi_ctrl #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 5,
  parameter int NUM_CS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrCtrl,
  input  logic [31:0]           wdata,
  output spi_pkg::engStrobe_t   strb,
  output logic                  sck,
  output logic [NUM_CS-1:0]     csReg,
  output logic                  loopReg,
  output logic [DIV_W-1:0]      divReg,
  output logic                  busy
);
  localparam int EDGES    = 2 * BYTE_W;
  localparam int EW       = $clog2(EDGES);
  localparam int LOOP_BIT = 3;
  localparam int START_BIT = 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic [DIV_W-1:0]  halfCnt;
  logic [EW-1:0]     edgeCnt;
  logic [NUM_CS-1:0] newCs, pendCs, pendCsNx;
  logic              newLoop, pendLoop, pendLoopNx;
  logic [DIV_W-1:0]  newDiv, pendDiv, pendDivNx;
  logic              pendValid, pendValidNx;
  logic              startReq, tick, lastEdge;

  // field extraction from a control write
  for (genvar i = 0; i < NUM_CS; i++) begin : g_csField
    assign newCs[i] = wdata[2*i];
  end
  assign newLoop  = wdata[LOOP_BIT];
  assign newDiv   = wdata[31 -: DIV_W];
  assign startReq = wdata[START_BIT];

  assign tick     = busy && (halfCnt == divReg);
  assign lastEdge = (edgeCnt == LAST_EDGE);

  // the last write seen while busy wins
  always_comb begin
    pendValidNx = pendValid;
    pendCsNx    = pendCs;
    pendLoopNx  = pendLoop;
    pendDivNx   = pendDiv;
    if (busy && wrCtrl) begin
      pendValidNx = 1'b1;
      pendCsNx    = newCs;
      pendLoopNx  = newLoop;
      pendDivNx   = newDiv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csReg     <= '1;
      loopReg   <= 1'b0;
      divReg    <= '0;
      busy      <= 1'b0;
      sck       <= 1'b0;
      halfCnt   <= '0;
      edgeCnt   <= '0;
      pendValid <= 1'b0;
      pendCs    <= '1;
      pendLoop  <= 1'b0;
      pendDiv   <= '0;
    end else if (!busy) begin
      if (wrCtrl) begin
        csReg   <= newCs;
        loopReg <= newLoop;
        divReg  <= newDiv;
        if (startReq) begin
          busy    <= 1'b1;
          halfCnt <= '0;
          edgeCnt <= '0;
          sck     <= 1'b0;
        end
      end
    end else begin
      pendValid <= pendValidNx;
      pendCs    <= pendCsNx;
      pendLoop  <= pendLoopNx;
      pendDiv   <= pendDivNx;
      if (tick) begin
        halfCnt <= '0;
        sck     <= ~sck;
        edgeCnt <= edgeCnt + 1'b1;
        if (lastEdge) begin
          busy      <= 1'b0;
          sck       <= 1'b0;
          pendValid <= 1'b0;
          if (pendValidNx) begin
            csReg   <= pendCsNx;
            loopReg <= pendLoopNx;
            divReg  <= pendDivNx;
          end
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.active = busy;
    strb.load   = !busy && wrCtrl && startReq;
    strb.sample = tick && !edgeCnt[0];
    strb.shift  = tick && edgeCnt[0];
    strb.finish = tick && lastEdge;
  end

  // R4
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R4
  half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> halfCnt <= divReg);
  // R9
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(csReg));
  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> edgeCnt >= $past(edgeCnt));
endmodule

// File: rtl/spi_datapath.sv
module spi_datapath #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  spi_pkg::engStrobe_t strb,
  input  logic                loopEn,
  input  logic                wrData,
  input  logic [BYTE_W-1:0]   wbyte,
  input  logic                miso,
  output logic                mosi,
  output logic [BYTE_W-1:0]   dataReg
);
  logic [BYTE_W-1:0] shiftReg;
  logic              rxBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg  <= '0;
      shiftReg <= '0;
      rxBit    <= 1'b0;
    end else begin
      if (!strb.active && wrData)
        dataReg <= wbyte;
      if (strb.load)
        shiftReg <= dataReg;
      if (strb.sample)
        rxBit <= loopEn ? shiftReg[BYTE_W-1] : miso;
      if (strb.shift)
        shiftReg <= {shiftReg[BYTE_W-2:0], rxBit};
      if (strb.finish)
        dataReg <= {shiftReg[BYTE_W-2:0], rxBit};
    end
  end

  assign mosi = strb.active & shiftReg[BYTE_W-1];

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.active && !strb.finish) |=> $stable(dataReg));
  // R5
  mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.active |-> !mosi);
endmodule

// File: rtl/spi_master_top.sv
module spi_master_top #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 5,
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csOut
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(4);

  spi_pkg::engStrobe_t strb;
  logic              selCtrl, selData, busy, loopReg;
  logic [DIV_W-1:0]  divReg;
  logic [BYTE_W-1:0] dataReg;
  logic [31:0]       ctrlWord;

  assign selCtrl = (busAddr == CTRL_OFS);
  assign selData = (busAddr == DATA_OFS);

  spi_ctrl #(.BYTE_W(BYTE_W), .DIV_W(DIV_W), .NUM_CS(NUM_CS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrCtrl(busWrEn && selCtrl), .wdata(busWrData),
    .strb(strb), .sck(sck), .csReg(csOut), .loopReg(loopReg),
    .divReg(divReg), .busy(busy));

  spi_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .loopEn(loopReg),
    .wrData(busWrEn && selData), .wbyte(busWrData[BYTE_W-1:0]),
    .miso(miso), .mosi(mosi), .dataReg(dataReg));

  always_comb begin
    ctrlWord = '0;
    for (int i = 0; i < NUM_CS; i++) ctrlWord[2*i] = csOut[i];
    ctrlWord[1] = busy;
    ctrlWord[3] = loopReg;
    ctrlWord[31 -: DIV_W] = divReg;
  end

  always_comb begin
    if (selCtrl)      busRdData = ctrlWord;
    else if (selData) busRdData = 32'(dataReg);
    else              busRdData = '0;
  end
endmodule

// File: tb/spi_master_top_tb.sv
module spi_master_top_tb;
  logic clk = 0, rst_n = 0;
  logic busWrEn = 0;
  logic [3:0] busAddr = 0;
  logic [31:0] busWrData = 0, busRdData;
  logic sck, mosi, miso = 0;
  logic [2:0] csOut;
  int nChecks = 0, nErr = 0;
  bit running = 0, done = 0;

  always #10 clk = ~clk;

  spi_master_top u_dut (.clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sck(sck), .mosi(mosi),
    .miso(miso), .csOut(csOut));

  // reference model state
  bit [2:0] mCs = 3'b111, pCs;
  bit mLoop = 0, pLoop, mBusy = 0, pendV = 0;
  int mDiv = 0, pDiv, mK = 0;
  bit [7:0] mData = 0, mTx = 0, mRx = 0;
  bit [15:0] lfsr = 16'hACE1;

  function automatic int hp(); return mDiv + 1; endfunction
  function automatic bit expSck(); return mBusy && ((mK / hp()) % 2 == 1); endfunction
  function automatic bit expMosi(); return mBusy && mTx[7 - mK / (2 * hp())]; endfunction
  function automatic logic [31:0] expRd(logic [3:0] a);
    logic [31:0] w = 0;
    if (a == 0) begin
      w[0] = mCs[0]; w[2] = mCs[1]; w[4] = mCs[2];
      w[1] = mBusy; w[3] = mLoop; w[31:27] = 5'(mDiv);
    end else if (a == 4) w = 32'(mData);
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mCs = 3'b111; mLoop = 0; mDiv = 0; mData = 0; mBusy = 0; pendV = 0; mK = 0;
    end else if (mBusy) begin
      if ((mK + 1) % hp() == 0 && ((mK + 1) / hp()) % 2 == 1)
        mRx = {mRx[6:0], mLoop ? mTx[7 - mK / (2 * hp())] : miso};
      if (busWrEn && busAddr == 0) begin
        pendV = 1; pCs = {busWrData[4], busWrData[2], busWrData[0]};
        pLoop = busWrData[3]; pDiv = int'(busWrData[31:27]);
      end
      mK++;
      if (mK == 16 * hp()) begin
        mBusy = 0; mData = mRx;
        if (pendV) begin mCs = pCs; mLoop = pLoop; mDiv = pDiv; end
        pendV = 0;
      end
    end else if (busWrEn && busAddr == 0) begin
      mCs = {busWrData[4], busWrData[2], busWrData[0]};
      mLoop = busWrData[3]; mDiv = int'(busWrData[31:27]);
      if (busWrData[1]) begin mBusy = 1; mK = 0; mTx = mData; mRx = 0; end
    end else if (busWrEn && busAddr == 4) mData = busWrData[7:0];
  end

  // pseudo-random serial input, changed away from the edge
  always @(posedge clk) begin
    #2 miso = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (running) begin
    chk("R4 sck", 32'(sck), 32'(expSck()));
    chk("R5 mosi", 32'(mosi), 32'(expMosi()));
    chk("R8 cs", 32'(csOut), 32'(mCs));
    chk("R2 readback", busRdData, expRd(busAddr));
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #2 busWrEn = 1; busAddr = a; busWrData = d;
    @(posedge clk); #2 busWrEn = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #2 busAddr = a;
    @(negedge clk); d = busRdData;
  endtask

  // counts busy cycles via the control word (address must be 0)
  task automatic countBusy(output int n);
    n = 0;
    busAddr = 0;
    @(negedge clk);
    while (busRdData[1] && n < 2000) begin n++; @(negedge clk); end
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sck", 32'(sck), 0);
    chk("R1 mosi", 32'(mosi), 0);
    chk("R1 cs", 32'(csOut), 32'h7);
    running = 1;
    rd(0, v); chk("R1 ctrl", v, 32'h15);
    rd(4, v); chk("R1 data", v, 0);

    // R2 / R10 register decode and width
    wr(4, 32'h12345678);
    rd(4, v); chk("R10 data low byte", v, 32'h78);
    wr(0, 32'h07FFFFE5);
    rd(0, v); chk("R2 reserved bits", v, 32'h05);
    wr(8, 32'hFFFFFFFF);
    rd(8, v); chk("R2 other address", v, 0);
    rd(4, v); chk("R2 ignored write", v, 32'h78);
    // R8 select levels
    wr(0, 32'h00000010);
    chk("R8 cs pattern", 32'(csOut), 32'h4);

    // R3 R6 transfer, N=0
    wr(4, 32'hA5);
    wr(0, 32'h00000016);
    countBusy(n); chk("R3 busy cycles N=0", n, 16);
    rd(4, v); chk("R6 rx byte", v, 32'(mData));

    // R7 loopback, N=2
    wr(4, 32'h3C);
    wr(0, 32'h1000001E);
    countBusy(n); chk("R3 busy cycles N=2", n, 48);
    rd(4, v); chk("R7 loopback", v, 32'h3C);

    // R9 R10 writes while busy, N=5
    wr(4, 32'hC3);
    wr(0, 32'h28000002);
    wr(0, 32'h08000017);
    chk("R9 cs held", 32'(csOut), 32'h0);
    wr(4, 32'h99);
    wr(0, 32'h10000012);
    countBusy(n);
    chk("R9 cs applied", 32'(csOut), 32'h4);
    rd(0, v); chk("R9 fields applied, no restart", v, 32'h10000010);
    rd(4, v); chk("R10 busy data write ignored", v, 32'(mData));

    // R4 longest divider, N=31
    wr(4, 32'h81);
    wr(0, 32'hF8000017);
    countBusy(n); chk("R3 busy cycles N=31", n, 512);
    rd(4, v); chk("R6 rx byte N=31", v, 32'(mData));

    running = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule